// File: doc/BRIEF.md
# Exception Entry and Reset Vector Unit

This block holds the system-control registers of a classic 32-bit MIPS-like core and performs the register side of taking a trap. The registers are the mode word (Status), the trap cause word (Cause), the saved return address (EPC) and a read-only processor identity word. A synchronous reset loads fixed power-up values and points the core at the boot ROM. A single-cycle trap strobe does four things on the same rising edge:

- It records why the trap happened and whether the faulting instruction sat in a branch delay slot.
- It saves the restart address.
- It pushes the three-level kernel/interrupt-enable stack.
- It chooses the handler address.

The core presents the current program counter, a delay-slot flag and a 5-bit trap code together with the strobe. It then fetches from the registered handler address one cycle later. The four registers can be read back through a small combinational read port indexed by register number. The reset values of Status and Cause are parameters, so a core can boot with other mode bits.

Top module: `cp0_trap_entry`

## Requirements
- R1: While reset is high at a rising edge, the next-PC output becomes 0xBFC00000 on that edge.
- R2: Reset loads Status with its reset parameter, default 0x10600000 (bits 28, 22 and 21 set). It loads Cause with its reset parameter, default 0, and loads EPC with 0.
- R3: The read port returns Status at index 12, Cause at 13, EPC at 14 and the identity word 0x00000002 at 15. Every other index reads 0.
- R4: On a trap, Cause becomes: bit 30 = delay-slot flag, bits 10..8 = their previous value, bits 6..2 = the 5-bit trap code. Every other bit is 0.
- R5: On a trap, EPC becomes PC-4 (modulo 2^32) when the delay-slot flag is set, and PC otherwise.
- R6: On a trap, the next-PC output is 0xBFC00180 if Status bit 22 was set at the strobe edge, and 0x80000080 if it was clear. The value appears on the registered output after that edge.
- R7: On a trap, Status bits 5..0 become the previous bits 3..0 shifted up by two, with bits 1..0 zero. Bits 31..6 are unchanged.
- R8: In a cycle with neither reset nor strobe, Status, Cause, EPC and next-PC keep their values, whatever the PC, flag and code inputs carry.
- R9: When reset and the trap strobe are high in the same cycle, reset wins and every register takes its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| take_exc_i | input | 1 | Trap strobe, one cycle per trap |
| pc_i | input | 32 | Program counter of the faulting instruction |
| in_delay_i | input | 1 | Faulting instruction is in a branch delay slot |
| exc_code_i | input | 5 | Trap code, stored at Cause bits 6..2 |
| rd_idx_i | input | 5 | Register number for the read port |
| rd_data_o | output | 32 | Combinational read data |
| next_pc_o | output | 32 | Registered fetch address after reset or trap |

## Verification
A wrong mode-stack state shows only at the next trap, or through a read at index 12. A stack shifted by the wrong amount therefore stays hidden until two traps in a row expose the second stack level. A bad boot-select bit appears one cycle after the strobe as the wrong handler address on next_pc_o. Lost Cause bits 10..8 show on the read port right after the first trap, but only if they were non-zero beforehand. For that reason the bench also runs a second instance whose Cause resets to all ones and whose Status resets with the boot-select bit clear and the low bits set.

// File: rtl/cp0_trap_pkg.sv
package cp0_trap_pkg;
   localparam int unsigned CP0_IDX_W = 5;
   localparam logic [CP0_IDX_W-1:0] IDX_STATUS = 5'd12;
   localparam logic [CP0_IDX_W-1:0] IDX_CAUSE  = 5'd13;
   localparam logic [CP0_IDX_W-1:0] IDX_EPC    = 5'd14;
   localparam logic [CP0_IDX_W-1:0] IDX_PRID   = 5'd15;
endpackage

// File: rtl/cp0_mode_stack.sv
module cp0_mode_stack #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned STACK_W     = 6,
   parameter int unsigned STACK_SHIFT = 2,
   parameter logic [XLEN-1:0] RESET_VAL = 32'h1060_0000
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            take_i,
   output logic [XLEN-1:0] status_o
);
   localparam int unsigned KEEP_LOW = STACK_W - STACK_SHIFT;

   logic [XLEN-1:0] status_q;
   logic [XLEN-1:0] status_push;

   always_comb begin
      status_push = status_q;
      status_push[STACK_W-1:0] = {status_q[KEEP_LOW-1:0], {STACK_SHIFT{1'b0}}};
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)       status_q <= RESET_VAL;
      else if (take_i) status_q <= status_push;
   end

   assign status_o = status_q;
endmodule

// File: rtl/cp0_cause_epc.sv
module cp0_cause_epc #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned CODE_W     = 5,
   parameter int unsigned CODE_LSB   = 2,
   parameter int unsigned KEEP_LSB   = 8,
   parameter int unsigned KEEP_W     = 3,
   parameter int unsigned BD_BIT     = 30,
   parameter int unsigned INSN_BYTES = 4,
   parameter logic [XLEN-1:0] CAUSE_RESET = '0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              take_i,
   input  logic [XLEN-1:0]   pc_i,
   input  logic              in_delay_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [XLEN-1:0]   cause_o,
   output logic [XLEN-1:0]   epc_o
);
   logic [XLEN-1:0] cause_q, epc_q;
   logic [XLEN-1:0] cause_next, epc_next;

   always_comb begin
      cause_next = '0;
      cause_next[BD_BIT] = in_delay_i;
      cause_next[KEEP_LSB +: KEEP_W] = cause_q[KEEP_LSB +: KEEP_W];
      cause_next[CODE_LSB +: CODE_W] = code_i;
      epc_next = in_delay_i ? (pc_i - XLEN'(INSN_BYTES)) : pc_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cause_q <= CAUSE_RESET;
         epc_q   <= '0;
      end else if (take_i) begin
         cause_q <= cause_next;
         epc_q   <= epc_next;
      end
   end

   assign cause_o = cause_q;
   assign epc_o   = epc_q;
endmodule

// File: rtl/cp0_vector_sel.sv
module cp0_vector_sel #(
   parameter int unsigned XLEN = 32,
   parameter bit VEC_SELECT = 1'b1,
   parameter logic [XLEN-1:0] RESET_PC   = 32'hBFC0_0000,
   parameter logic [XLEN-1:0] ROM_VECTOR = 32'hBFC0_0180,
   parameter logic [XLEN-1:0] RAM_VECTOR = 32'h8000_0080
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            take_i,
   input  logic            boot_sel_i,
   output logic [XLEN-1:0] next_pc_o
);
   logic [XLEN-1:0] handler;
   logic [XLEN-1:0] pc_q;

   generate
      if (VEC_SELECT) begin : g_two_vectors
         assign handler = boot_sel_i ? ROM_VECTOR : RAM_VECTOR;
      end else begin : g_ram_only
         assign handler = RAM_VECTOR;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i)       pc_q <= RESET_PC;
      else if (take_i) pc_q <= handler;
   end

   assign next_pc_o = pc_q;
endmodule

// File: rtl/cp0_trap_entry.sv
module cp0_trap_entry
   import cp0_trap_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned CODE_W      = 5,
   parameter int unsigned CODE_LSB    = 2,
   parameter int unsigned KEEP_LSB    = 8,
   parameter int unsigned KEEP_W      = 3,
   parameter int unsigned BD_BIT      = 30,
   parameter int unsigned BEV_BIT     = 22,
   parameter int unsigned STACK_W     = 6,
   parameter int unsigned STACK_SHIFT = 2,
   parameter int unsigned INSN_BYTES  = 4,
   parameter bit          VEC_SELECT  = 1'b1,
   parameter logic [XLEN-1:0] RESET_PC     = 32'hBFC0_0000,
   parameter logic [XLEN-1:0] RESET_STATUS = 32'h1060_0000,
   parameter logic [XLEN-1:0] RESET_CAUSE  = 32'h0000_0000,
   parameter logic [XLEN-1:0] PRID_VALUE   = 32'h0000_0002,
   parameter logic [XLEN-1:0] ROM_VECTOR   = 32'hBFC0_0180,
   parameter logic [XLEN-1:0] RAM_VECTOR   = 32'h8000_0080
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 take_exc_i,
   input  logic [XLEN-1:0]      pc_i,
   input  logic                 in_delay_i,
   input  logic [CODE_W-1:0]    exc_code_i,
   input  logic [CP0_IDX_W-1:0] rd_idx_i,
   output logic [XLEN-1:0]      rd_data_o,
   output logic [XLEN-1:0]      next_pc_o
);
   generate
      if (STACK_SHIFT == 0 || STACK_SHIFT >= STACK_W) begin : g_bad_stack
         $error("cp0_trap_entry: STACK_SHIFT must lie in 1..STACK_W-1");
      end
      if (CODE_LSB + CODE_W > KEEP_LSB) begin : g_bad_code
         $error("cp0_trap_entry: code field overlaps kept cause bits");
      end
      if (BD_BIT >= XLEN || BEV_BIT >= XLEN || KEEP_LSB + KEEP_W > BD_BIT) begin : g_bad_bits
         $error("cp0_trap_entry: bit position outside the word");
      end
   endgenerate

   logic [XLEN-1:0] status_w, cause_w, epc_w;

   cp0_mode_stack #(
      .XLEN(XLEN), .STACK_W(STACK_W), .STACK_SHIFT(STACK_SHIFT), .RESET_VAL(RESET_STATUS)
   ) u_stack (
      .clk_i(clk_i), .rst_i(rst_i), .take_i(take_exc_i), .status_o(status_w)
   );

   cp0_cause_epc #(
      .XLEN(XLEN), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB), .KEEP_LSB(KEEP_LSB),
      .KEEP_W(KEEP_W), .BD_BIT(BD_BIT), .INSN_BYTES(INSN_BYTES), .CAUSE_RESET(RESET_CAUSE)
   ) u_cause (
      .clk_i(clk_i), .rst_i(rst_i), .take_i(take_exc_i), .pc_i(pc_i),
      .in_delay_i(in_delay_i), .code_i(exc_code_i), .cause_o(cause_w), .epc_o(epc_w)
   );

   cp0_vector_sel #(
      .XLEN(XLEN), .VEC_SELECT(VEC_SELECT), .RESET_PC(RESET_PC),
      .ROM_VECTOR(ROM_VECTOR), .RAM_VECTOR(RAM_VECTOR)
   ) u_vec (
      .clk_i(clk_i), .rst_i(rst_i), .take_i(take_exc_i),
      .boot_sel_i(status_w[BEV_BIT]), .next_pc_o(next_pc_o)
   );

   always_comb begin
      case (rd_idx_i)
         IDX_STATUS: rd_data_o = status_w;
         IDX_CAUSE:  rd_data_o = cause_w;
         IDX_EPC:    rd_data_o = epc_w;
         IDX_PRID:   rd_data_o = PRID_VALUE;
         default:    rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/cp0_trap_entry_chk.sv
module cp0_trap_entry_chk
   import cp0_trap_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned CODE_W   = 5,
   parameter int unsigned CODE_LSB = 2,
   parameter int unsigned KEEP_LSB = 8,
   parameter int unsigned KEEP_W   = 3,
   parameter int unsigned BD_BIT   = 30,
   parameter int unsigned BEV_BIT  = 22,
   parameter int unsigned INSN_BYTES = 4,
   parameter logic [XLEN-1:0] RESET_PC     = 32'hBFC0_0000,
   parameter logic [XLEN-1:0] RESET_STATUS = 32'h1060_0000,
   parameter logic [XLEN-1:0] RESET_CAUSE  = 32'h0,
   parameter logic [XLEN-1:0] PRID_VALUE   = 32'h2,
   parameter logic [XLEN-1:0] ROM_VECTOR   = 32'hBFC0_0180,
   parameter logic [XLEN-1:0] RAM_VECTOR   = 32'h8000_0080
) (
   input logic                 clk_i,
   input logic                 rst_i,
   input logic                 take_i,
   input logic [XLEN-1:0]      pc_i,
   input logic                 bd_i,
   input logic [CODE_W-1:0]    code_i,
   input logic [CP0_IDX_W-1:0] rd_idx_i,
   input logic [XLEN-1:0]      rd_data_i,
   input logic [XLEN-1:0]      next_pc_i,
   input logic [XLEN-1:0]      status_i,
   input logic [XLEN-1:0]      cause_i,
   input logic [XLEN-1:0]      epc_i
);
   localparam logic [XLEN-1:0] CAUSE_MASK =
      (XLEN'(1) << BD_BIT) |
      (((XLEN'(1) << KEEP_W) - XLEN'(1)) << KEEP_LSB) |
      (((XLEN'(1) << CODE_W) - XLEN'(1)) << CODE_LSB);

   logic started_q = 1'b0;
   always_ff @(posedge clk_i) started_q <= 1'b1;

   a_r1_reset_pc: assert property (@(posedge clk_i)
      rst_i |=> next_pc_i == RESET_PC);

   a_r2_reset_regs: assert property (@(posedge clk_i)
      rst_i |=> (status_i == RESET_STATUS && cause_i == RESET_CAUSE && epc_i == '0));

   a_r3_prid_read: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_idx_i == IDX_PRID) |-> rd_data_i == PRID_VALUE);

   a_r3_unmapped_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_idx_i < IDX_STATUS || rd_idx_i > IDX_PRID) |-> rd_data_i == '0);

   a_r4_cause_fields: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q && take_i) |=>
         (cause_i[BD_BIT] == $past(bd_i)) &&
         (cause_i[CODE_LSB +: CODE_W] == $past(code_i)) &&
         (cause_i[KEEP_LSB +: KEEP_W] == $past(cause_i[KEEP_LSB +: KEEP_W])) &&
         ((cause_i & ~CAUSE_MASK) == '0));

   a_r5_epc: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q && take_i) |=>
         epc_i == ($past(bd_i) ? $past(pc_i) - XLEN'(INSN_BYTES) : $past(pc_i)));

   a_r6_vector: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q && take_i) |=>
         next_pc_i == ($past(status_i[BEV_BIT]) ? ROM_VECTOR : RAM_VECTOR));

   a_r7_stack: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q && take_i) |=>
         (status_i[5:0] == {$past(status_i[3:0]), 2'b00}) &&
         (status_i[XLEN-1:6] == $past(status_i[XLEN-1:6])));

   a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      (started_q && !take_i) |=>
         ($stable(status_i) && $stable(cause_i) && $stable(epc_i) && $stable(next_pc_i)));

   a_r9_reset_wins: assert property (@(posedge clk_i)
      (rst_i && take_i) |=> (next_pc_i == RESET_PC && status_i == RESET_STATUS));
endmodule

bind cp0_trap_entry cp0_trap_entry_chk #(
   .XLEN(XLEN), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB), .KEEP_LSB(KEEP_LSB),
   .KEEP_W(KEEP_W), .BD_BIT(BD_BIT), .BEV_BIT(BEV_BIT), .INSN_BYTES(INSN_BYTES),
   .RESET_PC(RESET_PC), .RESET_STATUS(RESET_STATUS), .RESET_CAUSE(RESET_CAUSE),
   .PRID_VALUE(PRID_VALUE), .ROM_VECTOR(ROM_VECTOR), .RAM_VECTOR(RAM_VECTOR)
) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .take_i(take_exc_i), .pc_i(pc_i), .bd_i(in_delay_i),
   .code_i(exc_code_i), .rd_idx_i(rd_idx_i), .rd_data_i(rd_data_o), .next_pc_i(next_pc_o),
   .status_i(status_w), .cause_i(cause_w), .epc_i(epc_w)
);

// File: tb/cp0_trap_entry_tb_top.sv
`timescale 1ns/1ps
module cp0_trap_entry_tb_top;
   localparam logic [31:0] ALT_STATUS = 32'h1020_000F;
   localparam logic [31:0] ALT_CAUSE  = 32'hFFFF_FFFF;
   localparam int NVEC = 6;
   // {pc, delay flag, code}
   localparam logic [37:0] VEC [NVEC] = '{
      {32'h8001_0000, 1'b0, 5'h08},
      {32'h8002_0004, 1'b1, 5'h09},
      {32'hBFC0_0010, 1'b0, 5'h1F},
      {32'h0000_0004, 1'b1, 5'h00},
      {32'h0000_0000, 1'b1, 5'h0C},
      {32'hFFFF_FFFC, 1'b0, 5'h04}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic take = 1'b0;
   logic [31:0] pc = '0;
   logic bd = 1'b0;
   logic [4:0] code = '0;
   logic [4:0] rd_idx = '0;
   logic [31:0] rd_a, rd_b, npc_a, npc_b;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] m_st [2];
   logic [31:0] m_ca [2];
   logic [31:0] m_ep [2];
   logic [31:0] m_pc [2];

   always #10 clk = ~clk;

   cp0_trap_entry dut_i (
      .clk_i(clk), .rst_i(rst), .take_exc_i(take), .pc_i(pc), .in_delay_i(bd),
      .exc_code_i(code), .rd_idx_i(rd_idx), .rd_data_o(rd_a), .next_pc_o(npc_a)
   );

   cp0_trap_entry #(.RESET_STATUS(ALT_STATUS), .RESET_CAUSE(ALT_CAUSE)) dut_alt_i (
      .clk_i(clk), .rst_i(rst), .take_exc_i(take), .pc_i(pc), .in_delay_i(bd),
      .exc_code_i(code), .rd_idx_i(rd_idx), .rd_data_o(rd_b), .next_pc_o(npc_b)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] idx, output logic [31:0] a, output logic [31:0] b);
      rd_idx = idx;
      #1;
      a = rd_a;
      b = rd_b;
   endtask

   task automatic model_reset();
      m_st[0] = 32'h1060_0000; m_ca[0] = 32'h0;    m_ep[0] = 32'h0; m_pc[0] = 32'hBFC0_0000;
      m_st[1] = ALT_STATUS;    m_ca[1] = ALT_CAUSE; m_ep[1] = 32'h0; m_pc[1] = 32'hBFC0_0000;
   endtask

   task automatic model_trap(input logic [31:0] p, input logic d, input logic [4:0] c);
      for (int k = 0; k < 2; k++) begin
         m_pc[k] = m_st[k][22] ? 32'hBFC0_0180 : 32'h8000_0080;
         m_ca[k] = ({31'b0, d} << 30) | (m_ca[k] & 32'h0000_0700) | ({27'b0, c} << 2);
         m_ep[k] = d ? p - 32'd4 : p;
         m_st[k] = (m_st[k] & ~32'h3F) | ((m_st[k] & 32'hF) << 2);
      end
   endtask

   task automatic check_all(input string ctx);
      logic [31:0] a, b;
      chk({ctx, " R6/R1 next_pc main"}, npc_a, m_pc[0]);
      chk({ctx, " R6/R1 next_pc alt"},  npc_b, m_pc[1]);
      rd(5'd12, a, b);
      chk({ctx, " R7/R2 status main"}, a, m_st[0]);
      chk({ctx, " R7/R2 status alt"},  b, m_st[1]);
      rd(5'd13, a, b);
      chk({ctx, " R4/R2 cause main"}, a, m_ca[0]);
      chk({ctx, " R4/R2 cause alt"},  b, m_ca[1]);
      rd(5'd14, a, b);
      chk({ctx, " R5/R2 epc main"}, a, m_ep[0]);
      chk({ctx, " R5/R2 epc alt"},  b, m_ep[1]);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] a, b;
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 R2: reset state
      check_all("reset");
      // R3: identity and unmapped indexes
      rd(5'd15, a, b);
      chk("R3 prid main", a, 32'h2);
      chk("R3 prid alt", b, 32'h2);
      rd(5'd0, a, b);
      chk("R3 index 0 reads zero", a, 32'h0);
      rd(5'd11, a, b);
      chk("R3 index 11 reads zero", b, 32'h0);
      rd(5'd16, a, b);
      chk("R3 index 16 reads zero", a, 32'h0);

      // R4 R5 R6 R7: vector walk
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         pc = VEC[i][37:6];
         bd = VEC[i][5];
         code = VEC[i][4:0];
         take = 1'b1;
         @(negedge clk);
         take = 1'b0;
         model_trap(VEC[i][37:6], VEC[i][5], VEC[i][4:0]);
         check_all($sformatf("vec%0d", i));
      end

      // R8: idle cycles with busy inputs change nothing
      pc = 32'h1234_5678;
      bd = 1'b1;
      code = 5'h15;
      repeat (3) @(negedge clk);
      check_all("idle R8");

      // R9: reset and strobe together
      @(negedge clk);
      rst = 1'b1;
      take = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      take = 1'b0;
      model_reset();
      check_all("reset+strobe R9");

      // back-to-back traps after reset (R7 second level, R4 kept bits)
      @(negedge clk);
      pc = 32'h8000_1000; bd = 1'b0; code = 5'h01; take = 1'b1;
      @(negedge clk);
      model_trap(32'h8000_1000, 1'b0, 5'h01);
      pc = 32'h8000_2000; bd = 1'b1; code = 5'h02;
      @(negedge clk);
      take = 1'b0;
      model_trap(32'h8000_2000, 1'b1, 5'h02);
      check_all("back-to-back R7");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule